// File: doc/BRIEF.md
# I/O Window Address Decoder

This block routes a single I/O access to the device that owns the addressed port. Each device has a fixed number of I/O windows. A window has a base port and a handler-bound flag, and every window spans the same fixed number of ports. On each access the decoder compares the port against every window of every device at the same time. It then picks one owner, forwards the access to that device with the offset inside the window, and returns the device's read data together with an interrupt line number.

Reads that fall outside every bound window return all ones, and writes that miss are dropped. When the selected device raises its per-access interrupt flag, the decoder returns that device's configured line number instead of the flag. When no interrupt is raised, it returns 0xFF.

The access path has two register stages:
- The owner selection is registered, so the device sees the access one cycle after the decoder accepts it.
- The device's combinational answer is registered again, so the response appears two cycles after acceptance.

Top module: `iowin_decoder`

## Requirements
- R1: A window matches when it is bound and `masked_base <= port < masked_base + WIN_SIZE`, where `masked_base` is the window base with bit 0 (the type bit) forced to 0. On a match, `tgt_valid` is 1 in the cycle after acceptance.
- R2: A window whose bit in `win_bound` is 0 never matches, whatever its base.
- R3: When several windows match, the one with the highest flat index `dev*NWIN + win` wins. Flat window `i` uses `win_base[16*i +: 16]` and `win_bound[i]`. The owner appears on `tgt_dev` and `tgt_win`.
- R4: `tgt_offset` equals `port - masked_base` of the selected window, taken over the low log2(WIN_SIZE) bits.
- R5: A read that matches no window asserts no `tgt_valid`, and its `rsp_rdata` is 0xFFFFFFFF.
- R6: For a read that matches, `rsp_rdata` equals the `tgt_rdata` value present during the `tgt_valid` cycle.
- R7: If the access matched and `tgt_irq` is 1 during the `tgt_valid` cycle, `rsp_irq_line` equals `dev_line[8*d +: 8]` of the selected device `d`. Otherwise `rsp_irq_line` is 0xFF.
- R8: On a matched access, `tgt_write`, `tgt_size` and `tgt_wdata` carry the accepted access's direction, size and data. A write response has `rsp_rdata` equal to 0.
- R9: While reset is asserted, `tgt_valid` and `rsp_valid` are 0 and `rsp_irq_line` is 0xFF.
- R10: `rsp_valid` is 1 exactly two cycles after each accepted access (`acc_valid` high at a clock edge) and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 3 | Access size in bytes |
| acc_port | input | 16 | Port address |
| acc_wdata | input | 32 | Write data |
| win_base | input | NDEV*NWIN*16 | Base port of each window, flat index dev*NWIN+win |
| win_bound | input | NDEV*NWIN | Handler bound to window |
| dev_line | input | NDEV*8 | Interrupt line number of each device |
| tgt_valid | output | 1 | Forwarded access to a device |
| tgt_dev | output | DEV_W | Selected device |
| tgt_win | output | WIN_W | Selected window in that device |
| tgt_offset | output | OFS_W | Port offset inside the window |
| tgt_write | output | 1 | Forwarded direction |
| tgt_size | output | 3 | Forwarded size |
| tgt_wdata | output | 32 | Forwarded write data |
| tgt_rdata | input | 32 | Device read data, combinational in the tgt_valid cycle |
| tgt_irq | input | 1 | Device interrupt flag for this access |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data |
| rsp_irq_line | output | 8 | Interrupt line, 0xFF for none |

## Verification
An access accepted at clock edge k produces its forwarded fields on the `tgt_*` outputs after edge k. Its response fields become visible after edge k+1.

The bench drives each access at a falling edge. It samples the forwarded fields one time unit after edge k and the response one time unit after edge k+1. The bench's device model answers from the forwarded fields within the same cycle, so the expected read data and interrupt line are fixed by the time edge k+1 registers them.

// File: rtl/iowin_pkg.sv
`timescale 1ns/1ps
package iowin_pkg;
  localparam int PORT_W = 16;
  localparam int DATA_W = 32;
  localparam int LINE_W = 8;
  localparam int SIZE_W = 3;

  typedef logic [PORT_W-1:0] port_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [LINE_W-1:0] line_t;

  localparam line_t NO_LINE   = '1;
  localparam data_t FLOAT_HI  = '1;
endpackage

// File: rtl/iowin_match.sv
`timescale 1ns/1ps
module iowin_match
  import iowin_pkg::*;
#(
  parameter int WIN_SIZE = 16,
  localparam int OFS_W = (WIN_SIZE > 1) ? $clog2(WIN_SIZE) : 1
) (
  input  port_t             port,
  input  port_t             base,
  input  logic              bound,
  output logic              hit,
  output logic [OFS_W-1:0]  offset
);
  port_t              base_m;
  logic [PORT_W:0]    upper;

  always_comb begin
    base_m = base & ~port_t'(1);
    upper  = {1'b0, base_m} + (PORT_W+1)'(WIN_SIZE);
    hit    = bound && (port >= base_m) && ({1'b0, port} < upper);
    offset = OFS_W'(port - base_m);
  end
endmodule

// File: rtl/iowin_select.sv
`timescale 1ns/1ps
module iowin_select #(
  parameter int NW = 48,
  localparam int IDX_W = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic [NW-1:0]    hits,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < NW; i++) begin
      if (hits[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/iowin_decoder.sv
`timescale 1ns/1ps
module iowin_decoder
  import iowin_pkg::*;
#(
  parameter int NDEV = 8,
  parameter int NWIN = 6,
  parameter int WIN_SIZE = 16,
  localparam int NW = NDEV * NWIN,
  localparam int DEV_W = (NDEV > 1) ? $clog2(NDEV) : 1,
  localparam int WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int OFS_W = (WIN_SIZE > 1) ? $clog2(WIN_SIZE) : 1,
  localparam int IDX_W = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  input  logic                 acc_write,
  input  logic [2:0]           acc_size,
  input  logic [15:0]          acc_port,
  input  logic [31:0]          acc_wdata,
  input  logic [NW*16-1:0]     win_base,
  input  logic [NW-1:0]        win_bound,
  input  logic [NDEV*8-1:0]    dev_line,
  output logic                 tgt_valid,
  output logic [DEV_W-1:0]     tgt_dev,
  output logic [WIN_W-1:0]     tgt_win,
  output logic [OFS_W-1:0]     tgt_offset,
  output logic                 tgt_write,
  output logic [2:0]           tgt_size,
  output logic [31:0]          tgt_wdata,
  input  logic [31:0]          tgt_rdata,
  input  logic                 tgt_irq,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  output logic [7:0]           rsp_irq_line
);
  logic [NW-1:0]    hits;
  logic [OFS_W-1:0] ofs_all [NW];

  for (genvar i = 0; i < NW; i++) begin : g_win
    iowin_match #(.WIN_SIZE(WIN_SIZE)) u_match (
      .port   (acc_port),
      .base   (win_base[i*PORT_W +: PORT_W]),
      .bound  (win_bound[i]),
      .hit    (hits[i]),
      .offset (ofs_all[i])
    );
  end

  logic             any_hit;
  logic [IDX_W-1:0] sel_idx;

  iowin_select #(.NW(NW)) u_sel (
    .hits (hits),
    .any  (any_hit),
    .idx  (sel_idx)
  );

  // stage 1: owner selection
  logic             acc_q, hit_q, wr_q;
  logic [DEV_W-1:0] dev_q, dev_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic [SIZE_W-1:0] size_q;
  data_t            wdata_q;

  always_comb begin
    dev_d = DEV_W'(int'(sel_idx) / NWIN);
    win_d = WIN_W'(int'(sel_idx) % NWIN);
    ofs_d = ofs_all[sel_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      acc_q <= acc_valid;
      hit_q <= acc_valid & any_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      dev_q   <= '0;
      win_q   <= '0;
      ofs_q   <= '0;
      size_q  <= '0;
      wdata_q <= '0;
    end else if (acc_valid) begin
      wr_q    <= acc_write;
      dev_q   <= dev_d;
      win_q   <= win_d;
      ofs_q   <= ofs_d;
      size_q  <= acc_size;
      wdata_q <= acc_wdata;
    end
  end

  assign tgt_valid  = hit_q;
  assign tgt_dev    = dev_q;
  assign tgt_win    = win_q;
  assign tgt_offset = ofs_q;
  assign tgt_write  = wr_q;
  assign tgt_size   = size_q;
  assign tgt_wdata  = wdata_q;

  // stage 2: response
  data_t rdata_d;
  line_t line_d;

  always_comb begin
    if (wr_q)       rdata_d = '0;
    else if (hit_q) rdata_d = tgt_rdata;
    else            rdata_d = FLOAT_HI;
    line_d = (hit_q && tgt_irq) ? dev_line[int'(dev_q)*LINE_W +: LINE_W] : NO_LINE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= acc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata    <= '0;
      rsp_irq_line <= NO_LINE;
    end else if (acc_q) begin
      rsp_rdata    <= rdata_d;
      rsp_irq_line <= line_d;
    end
  end
endmodule

// File: rtl/iowin_decoder_chk.sv
`timescale 1ns/1ps
module iowin_decoder_chk #(
  parameter int NW = 48,
  parameter int NWIN = 6,
  parameter int DEV_W = 3,
  parameter int WIN_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             acc_write,
  input logic [NW-1:0]    win_bound,
  input logic             tgt_valid,
  input logic [DEV_W-1:0] tgt_dev,
  input logic [WIN_W-1:0] tgt_win,
  input logic             tgt_write,
  input logic [31:0]      tgt_rdata,
  input logic             rsp_valid,
  input logic [31:0]      rsp_rdata,
  input logic [7:0]       rsp_irq_line
);
  assert_rsp_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(acc_valid, 2));

  assert_bound_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> win_bound[int'(tgt_dev)*NWIN + int'(tgt_win)]);

  assert_read_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && !tgt_write) |=> (rsp_rdata == $past(tgt_rdata)));

  assert_write_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && tgt_write) |=> (rsp_rdata == 32'h0));

  assert_miss_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(tgt_valid) && !$past(acc_write, 2)) |-> (rsp_rdata == 32'hFFFF_FFFF));

  assert_miss_noline_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(tgt_valid)) |-> (rsp_irq_line == 8'hFF));
endmodule

bind iowin_decoder iowin_decoder_chk #(
  .NW(NW), .NWIN(NWIN), .DEV_W(DEV_W), .WIN_W(WIN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .win_bound(win_bound), .tgt_valid(tgt_valid), .tgt_dev(tgt_dev),
  .tgt_win(tgt_win), .tgt_write(tgt_write), .tgt_rdata(tgt_rdata),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_irq_line(rsp_irq_line)
);

// File: tb/iowin_decoder_test.sv
`timescale 1ns/1ps
module iowin_decoder_test;
  localparam int NDEV = 8;
  localparam int NWIN = 6;
  localparam int WS   = 16;
  localparam int NW   = NDEV * NWIN;

  logic clk, rst_n;
  logic acc_valid, acc_write;
  logic [2:0] acc_size;
  logic [15:0] acc_port;
  logic [31:0] acc_wdata;
  logic [NW*16-1:0] win_base;
  logic [NW-1:0] win_bound;
  logic [NDEV*8-1:0] dev_line;
  logic tgt_valid, tgt_write, tgt_irq, rsp_valid;
  logic [2:0] tgt_dev, tgt_win, tgt_size;
  logic [3:0] tgt_offset;
  logic [31:0] tgt_wdata, tgt_rdata, rsp_rdata;
  logic [7:0] rsp_irq_line;

  int checks = 0;
  int errors = 0;

  iowin_decoder #(.NDEV(NDEV), .NWIN(NWIN), .WIN_SIZE(WS)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_size(acc_size), .acc_port(acc_port), .acc_wdata(acc_wdata),
    .win_base(win_base), .win_bound(win_bound), .dev_line(dev_line),
    .tgt_valid(tgt_valid), .tgt_dev(tgt_dev), .tgt_win(tgt_win),
    .tgt_offset(tgt_offset), .tgt_write(tgt_write), .tgt_size(tgt_size),
    .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata), .tgt_irq(tgt_irq),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_irq_line(rsp_irq_line)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] dev_data(int d, int w, int o);
    return 32'hC0DE_0000 | 32'(d << 12) | 32'(w << 8) | 32'(o);
  endfunction

  // device model behind the windows
  always_comb begin
    tgt_rdata = dev_data(int'(tgt_dev), int'(tgt_win), int'(tgt_offset));
    tgt_irq   = tgt_offset[0] ^ tgt_dev[0];
  end

  function automatic logic [15:0] mbase(int i);
    return win_base[i*16 +: 16] & 16'hFFFE;
  endfunction

  function automatic int exp_idx(logic [15:0] p);
    int r = -1;
    for (int i = 0; i < NW; i++)
      if (win_bound[i] && p >= mbase(i) && 32'(p) < 32'(mbase(i)) + WS) r = i;
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(logic wr, logic [15:0] port, logic [31:0] wd, logic [2:0] sz, string vtag);
    int ei, ed, ew, eo;
    logic [31:0] erd;
    logic [7:0]  eline;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_port = port; acc_wdata = wd; acc_size = sz;
    @(posedge clk); #1;
    acc_valid = 1'b0;
    ei = exp_idx(port);
    eline = 8'hFF;
    if (ei >= 0) begin
      ed = ei / NWIN; ew = ei % NWIN;
      eo = int'((port - mbase(ei)) & 16'(WS-1));
      chk(vtag, 32'(tgt_valid), 1);
      chk("R3 dev", 32'(tgt_dev), 32'(ed));
      chk("R3 win", 32'(tgt_win), 32'(ew));
      chk("R4", 32'(tgt_offset), 32'(eo));
      chk("R8 dir", 32'(tgt_write), 32'(wr));
      chk("R8 size", 32'(tgt_size), 32'(sz));
      if (wr) chk("R8 data", tgt_wdata, wd);
      erd = wr ? 32'h0 : dev_data(ed, ew, eo);
      if ((eo % 2) != (ed % 2)) eline = dev_line[ed*8 +: 8];
    end else begin
      chk(vtag, 32'(tgt_valid), 0);
      erd = wr ? 32'h0 : 32'hFFFF_FFFF;
    end
    @(posedge clk); #1;
    chk("R10", 32'(rsp_valid), 1);
    chk(wr ? "R8 rsp" : (ei >= 0 ? "R6" : "R5"), rsp_rdata, erd);
    chk("R7", 32'(rsp_irq_line), 32'(eline));
    @(posedge clk); #1;
    chk("R10 idle", 32'(rsp_valid), 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
    acc_size = '0; acc_port = '0; acc_wdata = '0;
    for (int i = 0; i < NW; i++) begin
      win_base[i*16 +: 16] = 16'h1000 + 16'(i * WS) + 16'(i % 2); // odd windows carry type bit
      win_bound[i] = 1'b1;
    end
    win_bound[15] = 1'b0;                         // device 2 window 3 unbound
    win_base[31*16 +: 16] = 16'h1001;             // device 5 window 1 overlaps window 0
    for (int d = 0; d < NDEV; d++) dev_line[d*8 +: 8] = 8'(d * 2 + 3);
    repeat (3) @(posedge clk);
    #1;
    chk("R9 tgt", 32'(tgt_valid), 0);
    chk("R9 rsp", 32'(rsp_valid), 0);
    chk("R9 line", 32'(rsp_irq_line), 32'hFF);
    @(negedge clk); rst_n = 1'b1;

    access(1'b0, 16'h0FFF, 32'h0, 3'd4, "R1 below");
    access(1'b0, 16'h1010, 32'h0, 3'd4, "R1 base");
    access(1'b0, 16'h101F, 32'h0, 3'd1, "R1 top");
    access(1'b0, 16'h1015, 32'h0, 3'd2, "R1 typebit");
    access(1'b0, 16'h1300, 32'h0, 3'd4, "R1 past end");
    access(1'b0, 16'h10F4, 32'h0, 3'd4, "R2");
    access(1'b1, 16'h10F4, 32'h1234_5678, 3'd4, "R2 write");
    access(1'b0, 16'h1003, 32'h0, 3'd4, "R3 overlap");
    access(1'b1, 16'h1008, 32'hDEAD_BEEF, 3'd2, "R8 write");
    access(1'b1, 16'h0100, 32'hCAFE_F00D, 3'd1, "R8 miss write");
    access(1'b0, 16'h12FF, 32'h0, 3'd1, "R1 last");

    for (int n = 0; n < 400; n++) begin
      logic [15:0] p;
      p = ($urandom % 4 == 0) ? 16'($urandom) : 16'h0FF0 + 16'($urandom % 800);
      access(1'($urandom), p, $urandom, 3'($urandom % 5), "R1 rand");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule